// File: doc/BRIEF.md
# Greedy Approximation Search Sequencer

This block steers a fault-injection experiment that decides how much random bit-flip probability each candidate register of a circuit can take while an output quality limit still holds. It owns a table of per-register flip probabilities. It changes that table one entry at a time through a write port that feeds an external injector. After each change it starts one measurement window on an external error monitor. When the monitor reports the window finished, the block reads the monitor's violation flag and either keeps the change or undoes it.

The search has two phases. In the pruning phase, each candidate is tried once at probability one half, which stands for removing that register completely. A candidate that passes keeps one half. A candidate that fails goes back to zero. In the refinement phase, the candidates that failed pruning are raised step by step in round-robin order. A candidate leaves the search the first time a raise causes a violation, and that raise is undone. It also leaves when it reaches one half. When no candidate remains, the block raises done. The table then holds the largest probability each register tolerated, and it can be read back. Probabilities are unsigned fractions of 2^PW, so one half is the code 2^(PW-1).

Top module: `approx_search_seq`

## Requirements
- R1: After reset the table is all zero and the block is idle with done low. A start pulse accepted while idle or done first writes 0 to every one of the N_CAND entries in ascending index order, one per cycle, before any measurement. A start pulse that arrives while a search runs has no effect.
- R2: Pruning phase: for candidates 0 to count-1 in ascending order, the block writes 128 (one half at PW=8) and starts one measurement. On a violation it writes 0 back to that entry. Otherwise the entry stays at 128.
- R3: meas_start is a one-cycle pulse, and no new measurement starts before meas_done has returned. The violation input is acted on only in the cycle meas_done is high, and is ignored at all other times.
- R4: Refinement works only on the entries that pruning reverted. Entries left at 128 by pruning are never written again in that run.
- R5: A refinement step writes min(old + delta, 128). A delta of 0 is used as 1, and a written value never exceeds 128.
- R6: If a refinement step causes a violation, the old value is written back and the entry is retired. An entry that reaches 128 without a violation is also retired.
- R7: Refinement visits the active entries in ascending index order, wrapping around, until none are left. Then done goes high and stays high until the next accepted start. While done is high there are no writes and no measurements.
- R8: rd_prob always shows the current table entry selected by rd_idx, in the same cycle. At done, each entry holds the largest probability tolerated for that register.
- R9: A count above N_CAND is treated as N_CAND. A count of 0 ends with an all-zero table after the clear. Entries at or above the count stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse for a new search |
| num_cand | input | IW+1 | Number of candidates, sampled at start |
| delta | input | PW | Refinement step, sampled at start |
| wr_en | output | 1 | Probability write strobe to the injector |
| wr_idx | output | IW | Register index of the write |
| wr_prob | output | PW | Probability written |
| meas_start | output | 1 | Starts one measurement window |
| meas_done | input | 1 | Monitor pulse: window finished |
| violation | input | 1 | Monitor flag, valid with meas_done |
| done | output | 1 | Search finished, table final |
| rd_idx | input | IW | Readback index |
| rd_prob | output | PW | Readback probability |

## Verification
A wrong active set or a wrong index shows at the write port within one measurement. The write there targets the wrong register, carries the wrong value, or is missing or extra. A bench that replays the greedy search on its own copy of the table therefore catches it at the next write. A corrupted table entry shows on the readback port in the following cycle, and it also changes the monitor's later verdicts, because the bench computes each verdict from the writes it has observed. A mistimed handshake shows either as a second meas_start while a window is still open, or as a measurement count that differs from the model's count.

// File: rtl/gsearch_pkg.sv
// Shared types for the greedy approximation search sequencer.
package gsearch_pkg;
    // Sequencer control states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_CSET,
        ST_FSCAN,
        ST_FSET,
        ST_LAUNCH,
        ST_WAIT,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/prob_store.sv
// Probability table: one write port, two combinational read ports.
// Assumes: at most one write per cycle; reset clears every entry.
module prob_store #(
    parameter int N_CAND = 64,
    parameter int PW     = 8,
    localparam int IW    = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [PW-1:0] wdata,
    input  logic [IW-1:0] raddr_a,
    output logic [PW-1:0] rdata_a,
    input  logic [IW-1:0] raddr_b,
    output logic [PW-1:0] rdata_b
);
    logic [PW-1:0] mem [N_CAND];

    // Clear on reset, otherwise take the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_CAND; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Both read ports are combinational.
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/active_set.sv
// Tracks which candidates are still in the refinement search.
// Assumes: set and clear never target an entry in the same cycle.
module active_set #(
    parameter int N_CAND = 64,
    localparam int IW    = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [IW-1:0] idx,
    output logic          is_active,
    output logic          any_active
);
    logic [N_CAND-1:0] bits_q;

    // Maintain one membership bit per candidate.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) begin
            bits_q <= '0;
        end else if (set_en) begin
            bits_q[idx] <= 1'b1;
        end else if (clr_en) begin
            bits_q[idx] <= 1'b0;
        end
    end

    assign is_active  = bits_q[idx];
    assign any_active = |bits_q;

    AST_SET_CLR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(set_en && clr_en)); // R6
endmodule

// File: rtl/raise_unit.sv
// Computes one refinement step, clamped to one half.
// Assumes: step is nonzero and cur is below one half.
module raise_unit #(
    parameter int PW = 8
) (
    input  logic [PW-1:0] cur,
    input  logic [PW-1:0] step,
    output logic [PW-1:0] next
);
    localparam logic [PW:0] HALF_W = (PW+1)'(1) << (PW-1);
    logic [PW:0] sum;

    // Add with one guard bit, then saturate at one half.
    always_comb begin
        sum  = {1'b0, cur} + {1'b0, step};
        next = (sum >= HALF_W) ? HALF_W[PW-1:0] : sum[PW-1:0];
    end
endmodule

// File: rtl/approx_search_seq.sv
// Two-phase greedy search over a candidate probability table.
// Assumes: the monitor answers every meas_start with exactly one meas_done pulse.
module approx_search_seq import gsearch_pkg::*; #(
    parameter int N_CAND = 64,
    parameter int PW     = 8,
    localparam int IW    = (N_CAND > 1) ? $clog2(N_CAND) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW:0]   num_cand,
    input  logic [PW-1:0] delta,
    output logic          wr_en,
    output logic [IW-1:0] wr_idx,
    output logic [PW-1:0] wr_prob,
    output logic          meas_start,
    input  logic          meas_done,
    input  logic          violation,
    output logic          done,
    input  logic [IW-1:0] rd_idx,
    output logic [PW-1:0] rd_prob
);
    localparam logic [PW-1:0] HALF  = {1'b1, {(PW-1){1'b0}}};
    localparam logic [IW:0]   N_W   = (IW+1)'(N_CAND);
    localparam logic [IW-1:0] LASTI = IW'(N_CAND - 1);

    seq_state_e    state_q;
    logic [IW-1:0] idx_q;
    logic [IW:0]   cnt_q;
    logic [PW-1:0] step_q, prev_q;
    logic          fine_q;

    logic [PW-1:0] cur_prob, raised;
    logic          is_active, any_active;
    logic          accept_start, last_cand, verdict, set_en, clr_en;
    logic [IW-1:0] next_idx;

    prob_store #(.N_CAND(N_CAND), .PW(PW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(wr_en), .waddr(wr_idx), .wdata(wr_prob),
        .raddr_a(idx_q), .rdata_a(cur_prob),
        .raddr_b(rd_idx), .rdata_b(rd_prob)
    );

    active_set #(.N_CAND(N_CAND)) u_active (
        .clk(clk), .rst_n(rst_n),
        .clr_all(accept_start), .set_en(set_en), .clr_en(clr_en),
        .idx(idx_q), .is_active(is_active), .any_active(any_active)
    );

    raise_unit #(.PW(PW)) u_raise (
        .cur(cur_prob), .step(step_q), .next(raised)
    );

    // Decode handshake and index helpers.
    always_comb begin
        accept_start = start && (state_q == ST_IDLE || state_q == ST_DONE);
        last_cand    = ({1'b0, idx_q} == (cnt_q - (IW+1)'(1)));
        next_idx     = last_cand ? '0 : idx_q + IW'(1);
        verdict      = (state_q == ST_WAIT) && meas_done;
        set_en       = verdict && violation && !fine_q;
        clr_en       = verdict && fine_q && (violation || cur_prob == HALF);
        meas_start   = (state_q == ST_LAUNCH);
        done         = (state_q == ST_DONE);
    end

    // Select the table write for the current state.
    always_comb begin
        wr_en   = 1'b0;
        wr_idx  = idx_q;
        wr_prob = '0;
        case (state_q)
            ST_CLEAR: wr_en = 1'b1;
            ST_CSET: begin
                wr_en   = 1'b1;
                wr_prob = HALF;
            end
            ST_FSET: begin
                wr_en   = 1'b1;
                wr_prob = raised;
            end
            ST_WAIT: begin
                if (meas_done && violation) begin
                    wr_en   = 1'b1;
                    wr_prob = fine_q ? prev_q : '0;
                end
            end
            default: ;
        endcase
    end

    // Sequence the clear, pruning and refinement phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            step_q  <= '0;
            prev_q  <= '0;
            fine_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        cnt_q   <= (num_cand > N_W) ? N_W : num_cand;
                        step_q  <= (delta == '0) ? PW'(1) : delta;
                        idx_q   <= '0;
                        fine_q  <= 1'b0;
                        state_q <= ST_CLEAR;
                    end
                end
                ST_CLEAR: begin
                    if (idx_q == LASTI) begin
                        idx_q   <= '0;
                        state_q <= (cnt_q == '0) ? ST_DONE : ST_CSET;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                    end
                end
                ST_CSET:   state_q <= ST_LAUNCH;
                ST_FSET: begin
                    prev_q  <= cur_prob;
                    state_q <= ST_LAUNCH;
                end
                ST_LAUNCH: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (meas_done) begin
                        idx_q <= next_idx;
                        if (!fine_q && !last_cand) begin
                            state_q <= ST_CSET;
                        end else begin
                            fine_q  <= 1'b1;
                            state_q <= ST_FSCAN;
                        end
                    end
                end
                ST_FSCAN: begin
                    if (!any_active)    state_q <= ST_DONE;
                    else if (is_active) state_q <= ST_FSET;
                    else                idx_q   <= next_idx;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_WRITE_CAP: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> wr_prob <= HALF); // R5
    AST_RAISE_UP: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_FSET) |-> wr_prob > cur_prob); // R5
    AST_PRUNED_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_FSET) |-> cur_prob != HALF); // R4
    AST_ONE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n) meas_start |=> (!meas_start && state_q == ST_WAIT)); // R3
    AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !any_active); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) done |-> (!wr_en && !meas_start)); // R7
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_CSET || state_q == ST_FSET) |-> ({1'b0, idx_q} < cnt_q)); // R9
endmodule

// File: tb/approx_search_seq_test.sv
// Self-checking bench: emulates the monitor and replays the greedy search.
module approx_search_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 64;
    localparam int PW   = 8;
    localparam int IW   = 6;
    localparam int HALF = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [IW:0]   num_cand = '0;
    logic [PW-1:0] delta = '0;
    logic          wr_en, meas_start, done;
    logic [IW-1:0] wr_idx;
    logic [PW-1:0] wr_prob, rd_prob;
    logic          meas_done = 1'b0;
    logic          violation = 1'b0;
    logic [IW-1:0] rd_idx = '0;

    approx_search_seq #(.N_CAND(N), .PW(PW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .num_cand(num_cand),
        .delta(delta), .wr_en(wr_en), .wr_idx(wr_idx), .wr_prob(wr_prob),
        .meas_start(meas_start), .meas_done(meas_done), .violation(violation),
        .done(done), .rd_idx(rd_idx), .rd_prob(rd_prob)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int sh[N];
    int mt[N];
    int lim[N];
    int budget;
    int e_idx[$];
    int e_val[$];
    string e_tag[$];
    bit pend = 0;
    int wait_ctr = 0;
    int cyc = 0;
    bit start_req = 0;
    int model_meas = 0;
    int seen_meas = 0;

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit oracle(input int t[N]);
        int s = 0;
        bit v = 0;
        for (int i = 0; i < N; i++) begin
            s += t[i];
            if (t[i] > lim[i]) v = 1;
        end
        if (s > budget) v = 1;
        return v;
    endfunction

    function automatic void push(input int i, input int v, input string tg);
        e_idx.push_back(i);
        e_val.push_back(v);
        e_tag.push_back(tg);
        mt[i] = v;
    endfunction

    // Behavioural replay of the two-phase greedy search.
    task automatic build(input int cnt_in, input int dl);
        int cnt;
        int d;
        bit act[N];
        bit any;
        cnt = (cnt_in > N) ? N : cnt_in;
        d = (dl == 0) ? 1 : dl;
        model_meas = 0;
        for (int i = 0; i < N; i++) begin
            push(i, 0, "R1");
            act[i] = 0;
        end
        for (int i = 0; i < cnt; i++) begin
            push(i, HALF, "R2");
            model_meas++;
            if (oracle(mt)) begin
                push(i, 0, "R2");
                act[i] = 1;
            end
        end
        do begin
            any = 0;
            for (int i = 0; i < cnt; i++) begin
                if (act[i]) begin
                    int old;
                    int nv;
                    old = mt[i];
                    nv = (old + d > HALF) ? HALF : old + d;
                    push(i, nv, "R5");
                    model_meas++;
                    if (oracle(mt)) begin
                        push(i, old, "R6");
                        act[i] = 0;
                    end else if (nv == HALF) begin
                        act[i] = 0;
                    end
                    any = 1;
                end
            end
        end while (any);
    endtask

    // One cycle: drive at the falling edge, then compare outputs.
    task automatic tick();
        @(negedge clk);
        meas_done = 1'b0;
        violation = (cyc % 2) == 1;  // noise, must be ignored (R3)
        start = start_req;
        start_req = 0;
        if (pend) begin
            if (wait_ctr == 0) begin
                meas_done = 1'b1;
                violation = oracle(sh);
                pend = 0;
                seen_meas++;
            end else begin
                wait_ctr--;
            end
        end
        rd_idx = IW'(cyc % N);
        #1;
        check(int'(rd_prob) == sh[rd_idx], "R8", "readback", int'(rd_prob), sh[rd_idx]);
        if (meas_start) begin
            check(!pend && !meas_done, "R3", "meas_start while window open", 1, 0);
            pend = 1;
            wait_ctr = cyc % 3;
        end
        if (wr_en) begin
            if (e_idx.size() == 0) begin
                check(0, "R7", "unexpected write index", int'(wr_idx), -1);
            end else begin
                string tg;
                int ei;
                int ev;
                tg = e_tag.pop_front();
                ei = e_idx.pop_front();
                ev = e_val.pop_front();
                check(int'(wr_idx) == ei, tg, "write index", int'(wr_idx), ei);
                check(int'(wr_prob) == ev, tg, "write value", int'(wr_prob), ev);
            end
            sh[wr_idx] = int'(wr_prob);
        end
        if (done && !start) begin
            check(e_idx.size() == 0, "R7", "done with writes pending", e_idx.size(), 0);
            check(!wr_en && !meas_start, "R7", "activity while done", int'(wr_en), 0);
        end
        cyc++;
    endtask

    task automatic run(input int cnt, input int dl, input int bud, input int poke);
        int n;
        budget = bud;
        build(cnt, dl);
        seen_meas = 0;
        num_cand = (IW+1)'(cnt);
        delta = PW'(dl);
        start_req = 1;
        n = 0;
        do begin
            tick();
            n++;
            if (n == poke) start_req = 1;  // start while busy (R1)
        end while (!(done && n > 1) && n < 20000);
        check(n < 20000, "R7", "search finished", n, 20000);
        check(e_idx.size() == 0, "R7", "expected writes left", e_idx.size(), 0);
        check(seen_meas == model_meas, "R3", "measurement count", seen_meas, model_meas);
        for (int i = 0; i < N; i++) begin
            rd_idx = IW'(i);
            #1;
            check(int'(rd_prob) == mt[i], "R8", "final table entry", int'(rd_prob), mt[i]);
        end
        for (int k = 0; k < 4; k++) begin
            tick();
            check(done == 1'b1, "R7", "done held", int'(done), 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);
        check(wr_en == 1'b0, "R1", "wr_en after reset", int'(wr_en), 0);
        check(meas_start == 1'b0, "R1", "meas_start after reset", int'(meas_start), 0);
        for (int i = 0; i < N; i++) begin
            rd_idx = IW'(i);
            #1;
            check(rd_prob == '0, "R1", "entry zero after reset", int'(rd_prob), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // Mixed limits, tight budget (R2 R4 R5 R6).
        for (int i = 0; i < N; i++) lim[i] = HALF;
        lim[1] = 40; lim[3] = 100; lim[4] = 10; lim[7] = 70;
        run(8, 16, 400, 0);

        // Count above table size, step not dividing one half, busy start (R9 R1).
        for (int i = 0; i < N; i++) lim[i] = 20 + (i * 37) % 120;
        run(70, 40, 3000, 100);

        // Single candidate, zero step used as one (R5 R9).
        for (int i = 0; i < N; i++) lim[i] = HALF;
        lim[0] = 5;
        run(1, 0, 1000, 0);

        // Zero count: clear only (R9).
        run(0, 8, 1000, 0);

        // Step past one half, every raise violates (R5 R6).
        for (int i = 0; i < N; i++) lim[i] = 60;
        run(5, 200, 10000, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule